// File: doc/BRIEF.md
# Counter Clock and Gate Router

This block sits in front of six 16-bit counter channels, grouped as two chips of three channels each. For every channel it chooses where the count clock comes from and where the gate level comes from. It also sets the direction of that channel's clock pin and gate pin. A small write-only register bus holds a 5-bit clock selector and a 5-bit gate selector per channel.

The clock sources are:
- the channel's own clock pin;
- a clock pin shared by the whole chip;
- one of six internal rates, made by a decade prescaler from the single system clock;
- a fixed high level or a fixed low level;
- the pattern-present signal;
- the output of the neighbouring counter, taken around a ring of chips.

The router produces a level for the selected clock source. It then turns every rising edge of that level into a one-cycle count-enable pulse. The counters use that pulse as an enable and run on the system clock, so no gated clock is ever created.

The gate sources are:
- fixed enable and fixed disable;
- the gate pin, straight or inverted;
- the output of the counter two places back in the ring, straight or inverted;
- three pattern signals, each straight or inverted: pattern present, a latch that sets when a pattern occurs, and a latch that records when the pattern goes away after it has occurred.

The counters and the pattern detector are outside this block; their outputs come in as inputs.

Top module: `ctr_route`

## Requirements
- R1: After reset every selector is 0. So `clk_oe_o` is all zero, `gate_oe_o` is all ones, `gate_o` is all ones and `tick_o` is all zero.
- R2: Clock selector 0 takes the channel's own pin `ext_clk_i[c]`. Selector 7 takes `chip_clk_i[c/3]`. A rising edge on the selected source gives `tick_o[c]` = 1 for exactly one cycle, one clock after the edge is sampled.
- R3: The internal-rate selectors give ticks with these periods, measured in system cycles, where P = `SYS_PER_20M`:
  - selector 11: P;
  - selector 1: 2P;
  - selector 2: 20P;
  - selector 3: 200P;
  - selector 4: 2000P;
  - selector 5: 20000P.
- R4: Clock selector 8 is a constant high level and selector 9 is a constant low level. Selector 10 follows `pat_i`. Selectors 12 to 31 give a constant low level. A change from low to high gives one tick.
- R5: Clock selector 6 takes the output of the previous channel on the same chip. For position 0 on a chip it takes position 2 of the preceding chip, and the chips form a ring.
- R6: Gate selector 0 is enabled and selector 1 is disabled. Selector 2 follows `gate_pin_i[c]` and selector 6 is its inverse.
- R7: Gate selector 3 is the inverted output of the channel two places back, and selector 7 is the same output without inversion. For position 2 the link is position 0 of the same chip. For positions 0 and 1 it is position n+1 of the preceding chip.
- R8: There are two pattern latches:
  - the occurred latch sets when `pat_i` is high;
  - the gone latch sets when `pat_i` is low after the occurred latch has set.

  Gate selectors use them as follows:
  - selector 8 is `pat_i`;
  - selector 9 is the occurred latch;
  - selector 10 is high until the gone latch sets;
  - selectors 11, 12 and 13 are the inverses of 8, 9 and 10.
- R9: A write to the all-ones address clears both pattern latches.
- R10: Gate selectors 4, 5 and 14 to 31 disable the gate.
- R11: `clk_oe_o[c]` is 1 exactly when the clock selector is not 0. `gate_oe_o[c]` is 1 exactly when the gate selector is not 2. `clk_lvl_o` and `gate_o` carry the routed levels that drive those pins.
- R12: `tick_o[c]` is never high on two cycles in a row, and it is high only in a cycle where `clk_lvl_o[c]` has just risen.
- R13: The write address is decoded as follows:
  - `{0, c}` writes the clock selector of channel c;
  - `{1, c}` writes the gate selector of channel c;
  - addresses of channels that do not exist have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: MSB picks the gate bank, the low bits pick the channel; all ones clears the pattern latches |
| wr_data | input | 5 | Selector value |
| ext_clk_i | input | 6 | Per-channel clock pin input |
| chip_clk_i | input | 2 | Clock pin shared by each chip |
| gate_pin_i | input | 6 | Per-channel gate pin input |
| ctr_out_i | input | 6 | Counter outputs |
| pat_i | input | 1 | Pattern-present signal |
| tick_o | output | 6 | Count-enable pulse per channel |
| clk_lvl_o | output | 6 | Routed clock level, driven onto the clock pin |
| clk_oe_o | output | 6 | Clock pin output enable |
| gate_o | output | 6 | Routed gate level |
| gate_oe_o | output | 6 | Gate pin output enable |

## Verification
The pin-direction outputs change one clock after a write. A new selector starts routing two clocks after its write, because the routed level is registered behind the selector. A direct source, such as a pin, a counter output or `pat_i`, reaches `tick_o`, `clk_lvl_o` and `gate_o` one clock after it is sampled. The pattern latches add one more clock. The bench drives inputs on the falling edge and samples on the falling edge that follows the counted number of rising edges. Internal rates are checked by counting ticks over windows that are whole multiples of the expected period, so the prescaler's phase does not matter.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;
    localparam int CH_PER_CHIP = 3;
    localparam int SEL_W       = 5;
    localparam int N_RATES     = 6;   // 20M, 10M, 1M, 100k, 10k, 1k
    localparam int N_DECADES   = 4;   // 1M, 100k, 10k, 1k

    // Clock selector codes
    localparam logic [SEL_W-1:0] CK_PIN   = 5'd0;
    localparam logic [SEL_W-1:0] CK_PREV  = 5'd6;
    localparam logic [SEL_W-1:0] CK_CHIP  = 5'd7;
    localparam logic [SEL_W-1:0] CK_HIGH  = 5'd8;
    localparam logic [SEL_W-1:0] CK_LOW   = 5'd9;
    localparam logic [SEL_W-1:0] CK_PAT   = 5'd10;
    localparam logic [SEL_W-1:0] CK_20M   = 5'd11;

    // Gate selector codes
    localparam logic [SEL_W-1:0] GT_ON     = 5'd0;
    localparam logic [SEL_W-1:0] GT_OFF    = 5'd1;
    localparam logic [SEL_W-1:0] GT_PIN    = 5'd2;
    localparam logic [SEL_W-1:0] GT_NN_INV = 5'd3;
    localparam logic [SEL_W-1:0] GT_PIN_N  = 5'd6;
    localparam logic [SEL_W-1:0] GT_NN     = 5'd7;
    localparam logic [SEL_W-1:0] GT_PAT    = 5'd8;
    localparam logic [SEL_W-1:0] GT_OCC    = 5'd9;
    localparam logic [SEL_W-1:0] GT_GONE   = 5'd10;
    localparam logic [SEL_W-1:0] GT_PAT_N  = 5'd11;
    localparam logic [SEL_W-1:0] GT_OCC_N  = 5'd12;
    localparam logic [SEL_W-1:0] GT_GONE_N = 5'd13;
endpackage

// File: rtl/ctr_route_prescaler.sv
module ctr_route_prescaler
    import ctr_route_pkg::*;
#(
    parameter int SYS_PER_20M = 2,
    localparam int C20W = $clog2(SYS_PER_20M + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [N_RATES-1:0] rate_tick_o
);
    typedef struct packed {
        logic [C20W-1:0]              c20;
        logic                         half;
        logic [N_DECADES-1:0][3:0]    dec;
    } pre_t;

    pre_t s_d, s_q;
    logic [N_RATES-1:0] tk;

    assign tk[0] = (s_q.c20 == C20W'(SYS_PER_20M - 1));
    assign tk[1] = tk[0] & s_q.half;

    for (genvar i = 0; i < N_DECADES; i++) begin : g_dec
        assign tk[i+2] = tk[i+1] & (s_q.dec[i] == 4'd9);
    end

    always_comb begin
        s_d = s_q;
        s_d.c20 = tk[0] ? '0 : s_q.c20 + 1'b1;
        if (tk[0]) s_d.half = ~s_q.half;
        for (int i = 0; i < N_DECADES; i++) begin
            if (tk[i+1]) s_d.dec[i] = (s_q.dec[i] == 4'd9) ? 4'd0 : s_q.dec[i] + 4'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rate_tick_o = tk;
endmodule

// File: rtl/ctr_route_pattern.sv
module ctr_route_pattern (
    input  logic clk,
    input  logic rst_n,
    input  logic pat_i,
    input  logic clr_i,
    output logic occ_o,
    output logic gone_o
);
    typedef struct packed {
        logic occ;
        logic gone;
    } lat_t;

    lat_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (pat_i)                s_d.occ  = 1'b1;
        if (s_q.occ && !pat_i)    s_d.gone = 1'b1;
        if (clr_i)                s_d      = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign occ_o  = s_q.occ;
    assign gone_o = s_q.gone;
endmodule

// File: rtl/ctr_route_chan.sv
module ctr_route_chan
    import ctr_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_wr_i,
    input  logic               gate_wr_i,
    input  logic [SEL_W-1:0]   wr_data_i,
    input  logic [N_RATES-1:0] rate_tick_i,
    input  logic               pin_clk_i,
    input  logic               chip_clk_i,
    input  logic               prev_out_i,
    input  logic               pin_gate_i,
    input  logic               back2_out_i,
    input  logic               pat_i,
    input  logic               occ_i,
    input  logic               gone_i,
    output logic               tick_o,
    output logic               clk_lvl_o,
    output logic               clk_oe_o,
    output logic               gate_o,
    output logic               gate_oe_o
);
    typedef struct packed {
        logic [SEL_W-1:0] csel;
        logic [SEL_W-1:0] gsel;
        logic             lvl;
        logic             tick;
        logic             gate;
    } ch_t;

    ch_t s_d, s_q;
    logic lvl_n, gate_n;

    always_comb begin
        s_d = s_q;
        if (clk_wr_i)  s_d.csel = wr_data_i;
        if (gate_wr_i) s_d.gsel = wr_data_i;

        case (s_q.csel)
            CK_PIN:                lvl_n = pin_clk_i;
            5'd1, 5'd2, 5'd3,
            5'd4, 5'd5:            lvl_n = rate_tick_i[s_q.csel[2:0]];
            CK_PREV:               lvl_n = prev_out_i;
            CK_CHIP:               lvl_n = chip_clk_i;
            CK_HIGH:               lvl_n = 1'b1;
            CK_LOW:                lvl_n = 1'b0;
            CK_PAT:                lvl_n = pat_i;
            CK_20M:                lvl_n = rate_tick_i[0];
            default:               lvl_n = 1'b0;
        endcase

        case (s_q.gsel)
            GT_ON:      gate_n = 1'b1;
            GT_OFF:     gate_n = 1'b0;
            GT_PIN:     gate_n = pin_gate_i;
            GT_NN_INV:  gate_n = ~back2_out_i;
            GT_PIN_N:   gate_n = ~pin_gate_i;
            GT_NN:      gate_n = back2_out_i;
            GT_PAT:     gate_n = pat_i;
            GT_OCC:     gate_n = occ_i;
            GT_GONE:    gate_n = ~gone_i;
            GT_PAT_N:   gate_n = ~pat_i;
            GT_OCC_N:   gate_n = ~occ_i;
            GT_GONE_N:  gate_n = gone_i;
            default:    gate_n = 1'b0;
        endcase

        s_d.lvl  = lvl_n;
        s_d.tick = lvl_n & ~s_q.lvl;
        s_d.gate = gate_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.gate <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o    = s_q.tick;
    assign clk_lvl_o = s_q.lvl;
    assign gate_o    = s_q.gate;
    assign clk_oe_o  = (s_q.csel != CK_PIN);
    assign gate_oe_o = (s_q.gsel != GT_PIN);
endmodule

// File: rtl/ctr_route.sv
module ctr_route
    import ctr_route_pkg::*;
#(
    parameter int NCHIP       = 2,
    parameter int SYS_PER_20M = 2,
    localparam int NCH = NCHIP * CH_PER_CHIP,
    localparam int CW  = $clog2(NCH + 1),
    localparam int AW  = CW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [SEL_W-1:0] wr_data,
    input  logic [NCH-1:0]   ext_clk_i,
    input  logic [NCHIP-1:0] chip_clk_i,
    input  logic [NCH-1:0]   gate_pin_i,
    input  logic [NCH-1:0]   ctr_out_i,
    input  logic             pat_i,
    output logic [NCH-1:0]   tick_o,
    output logic [NCH-1:0]   clk_lvl_o,
    output logic [NCH-1:0]   clk_oe_o,
    output logic [NCH-1:0]   gate_o,
    output logic [NCH-1:0]   gate_oe_o
);
    logic [N_RATES-1:0] rate_tick;
    logic               occ, gone, clr;

    assign clr = wr_en && (wr_addr == '1);

    ctr_route_prescaler #(.SYS_PER_20M(SYS_PER_20M)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_tick_o (rate_tick)
    );

    ctr_route_pattern u_pat (
        .clk    (clk),
        .rst_n  (rst_n),
        .pat_i  (pat_i),
        .clr_i  (clr),
        .occ_o  (occ),
        .gone_o (gone)
    );

    for (genvar g = 0; g < NCHIP; g++) begin : g_chip
        localparam int PREV_CHIP = (g + NCHIP - 1) % NCHIP;
        for (genvar n = 0; n < CH_PER_CHIP; n++) begin : g_ch
            localparam int C     = g * CH_PER_CHIP + n;
            localparam int PREV  = (n > 0) ? C - 1 : PREV_CHIP * CH_PER_CHIP + 2;
            localparam int BACK2 = (n == 2) ? g * CH_PER_CHIP
                                            : PREV_CHIP * CH_PER_CHIP + n + 1;
            logic clk_wr, gate_wr;
            assign clk_wr  = wr_en && (wr_addr == {1'b0, CW'(C)});
            assign gate_wr = wr_en && (wr_addr == {1'b1, CW'(C)});

            ctr_route_chan u_ch (
                .clk         (clk),
                .rst_n       (rst_n),
                .clk_wr_i    (clk_wr),
                .gate_wr_i   (gate_wr),
                .wr_data_i   (wr_data),
                .rate_tick_i (rate_tick),
                .pin_clk_i   (ext_clk_i[C]),
                .chip_clk_i  (chip_clk_i[g]),
                .prev_out_i  (ctr_out_i[PREV]),
                .pin_gate_i  (gate_pin_i[C]),
                .back2_out_i (ctr_out_i[BACK2]),
                .pat_i       (pat_i),
                .occ_i       (occ),
                .gone_i      (gone),
                .tick_o      (tick_o[C]),
                .clk_lvl_o   (clk_lvl_o[C]),
                .clk_oe_o    (clk_oe_o[C]),
                .gate_o      (gate_o[C]),
                .gate_oe_o   (gate_oe_o[C])
            );
        end
    end
endmodule

// File: rtl/ctr_route_chk.sv
module ctr_route_chk #(
    parameter int NCH = 6,
    parameter int AW  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [AW-1:0]  wr_addr,
    input logic [4:0]     wr_data,
    input logic [NCH-1:0] tick_o,
    input logic [NCH-1:0] clk_lvl_o,
    input logic [NCH-1:0] clk_oe_o,
    input logic [NCH-1:0] gate_oe_o
);
    localparam int CW = AW - 1;

    // R12: tick never high on consecutive cycles
    p_tick_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o & $past(tick_o)) == '0);

    // R12: tick only where the routed level has just risen
    p_tick_on_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((tick_o & ~clk_lvl_o) | (tick_o & $past(clk_lvl_o))) == '0);

    // R11: pin directions hold while nothing is written
    p_oe_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(clk_oe_o) && $stable(gate_oe_o)));

    for (genvar c = 0; c < NCH; c++) begin : g_c
        // R11, R13: clock pin direction follows the written clock selector
        p_clk_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == {1'b0, CW'(c)}) |=>
                (clk_oe_o[c] == ($past(wr_data) != 5'd0)));
        // R11, R13: gate pin direction follows the written gate selector
        p_gate_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == {1'b1, CW'(c)}) |=>
                (gate_oe_o[c] == ($past(wr_data) != 5'd2)));
    end
endmodule

bind ctr_route ctr_route_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tick_o    (tick_o),
    .clk_lvl_o (clk_lvl_o),
    .clk_oe_o  (clk_oe_o),
    .gate_oe_o (gate_oe_o)
);

// File: tb/ctr_route_bench.sv
`timescale 1ns/1ps
module ctr_route_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [4:0] wr_data = '0;
    logic [5:0] ext_clk_i = '0;
    logic [1:0] chip_clk_i = '0;
    logic [5:0] gate_pin_i = '0;
    logic [5:0] ctr_out_i = '0;
    logic       pat_i = 1'b0;
    logic [5:0] tick_o, clk_lvl_o, clk_oe_o, gate_o, gate_oe_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ctr_route u_ctr_route (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ext_clk_i(ext_clk_i), .chip_clk_i(chip_clk_i), .gate_pin_i(gate_pin_i),
        .ctr_out_i(ctr_out_i), .pat_i(pat_i), .tick_o(tick_o), .clk_lvl_o(clk_lvl_o),
        .clk_oe_o(clk_oe_o), .gate_o(gate_o), .gate_oe_o(gate_oe_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; ext_clk_i = '0; chip_clk_i = '0;
        gate_pin_i = '0; ctr_out_i = '0; pat_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Ends on the falling edge after the write edge: pin directions already updated
    task automatic wr(input logic [3:0] a, input logic [4:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 clk_oe", clk_oe_o, 6'h00);
        chk("R1 gate_oe", gate_oe_o, 6'h3f);
        chk("R1 gate", gate_o, 6'h3f);
        chk("R1 tick", tick_o, 6'h00);
    endtask

    task automatic t_pin_clocks();
        do_reset();
        ext_clk_i[0] = 1'b1;
        @(negedge clk);
        chk("R2 pin tick", tick_o[0], 1'b1);
        chk("R11 clk level", clk_lvl_o[0], 1'b1);
        @(negedge clk);
        chk("R12 single tick", tick_o[0], 1'b0);
        wr(4'd4, 5'd7);
        @(negedge clk);
        chip_clk_i[0] = 1'b1;
        @(negedge clk);
        chk("R2 other chip pin ignored", tick_o[4], 1'b0);
        chip_clk_i[1] = 1'b1;
        @(negedge clk);
        chk("R2 chip pin tick", tick_o[5:3], 3'b010);
    endtask

    task automatic t_ring_clock();
        do_reset();
        wr(4'd0, 5'd6);
        wr(4'd4, 5'd6);
        @(negedge clk);
        ctr_out_i = 6'b100000;
        @(negedge clk);
        chk("R5 ch0 from ch5", tick_o[0], 1'b1);
        chk("R5 ch4 idle", tick_o[4], 1'b0);
        ctr_out_i = 6'b101000;
        @(negedge clk);
        chk("R5 ch4 from ch3", tick_o[4], 1'b1);
        chk("R5 ch0 held level", tick_o[0], 1'b0);
    endtask

    task automatic count_ticks(input int ch, input int cycles, input int exp, input string tag);
        int n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tick_o[ch]) n++;
        end
        chk(tag, n, exp);
    endtask

    task automatic t_rates();
        do_reset();
        wr(4'd2, 5'd11);
        wr(4'd3, 5'd1);
        wr(4'd1, 5'd2);
        wr(4'd5, 5'd3);
        wr(4'd0, 5'd4);
        wr(4'd4, 5'd5);
        repeat (2) @(negedge clk);
        fork
            count_ticks(2, 400, 200, "R3 rate 20M");
            count_ticks(3, 400, 100, "R3 rate 10M");
            count_ticks(1, 400, 10, "R3 rate 1M");
            count_ticks(5, 4000, 10, "R3 rate 100k");
            count_ticks(0, 8000, 2, "R3 rate 10k");
            count_ticks(4, 40000, 1, "R3 rate 1k");
        join
    endtask

    task automatic t_fixed_clock();
        do_reset();
        wr(4'd1, 5'd9);
        @(negedge clk);
        chk("R4 low level", clk_lvl_o[1], 1'b0);
        wr(4'd1, 5'd8);
        @(negedge clk);
        chk("R4 high gives one tick", {tick_o[1], clk_lvl_o[1]}, 2'b11);
        @(negedge clk);
        chk("R4 high steady", {tick_o[1], clk_lvl_o[1]}, 2'b01);
        wr(4'd1, 5'd10);
        @(negedge clk);
        pat_i = 1'b1;
        @(negedge clk);
        chk("R4 pattern clock", tick_o[1], 1'b1);
        wr(4'd1, 5'd20);
        @(negedge clk);
        chk("R4 unused clock low", clk_lvl_o[1], 1'b0);
    endtask

    task automatic t_gates();
        do_reset();
        wr(4'd10, 5'd1);
        @(negedge clk);
        chk("R6 gate off", gate_o[2], 1'b0);
        wr(4'd10, 5'd2);
        chk("R11 gate pin input", gate_oe_o, 6'b111011);
        @(negedge clk);
        chk("R6 pin low", gate_o[2], 1'b0);
        gate_pin_i[2] = 1'b1;
        @(negedge clk);
        chk("R6 pin high", gate_o[2], 1'b1);
        wr(4'd10, 5'd6);
        @(negedge clk);
        chk("R6 pin inverted", gate_o[2], 1'b0);
    endtask

    task automatic t_ring_gate();
        do_reset();
        wr(4'd10, 5'd3);
        wr(4'd8, 5'd7);
        wr(4'd12, 5'd7);
        @(negedge clk);
        chk("R7 idle", gate_o & 6'b010101, 6'b000100);
        ctr_out_i = 6'b010001;
        @(negedge clk);
        chk("R7 ch2 inv ch0, ch0 from ch4", gate_o & 6'b010101, 6'b000001);
        ctr_out_i = 6'b000100;
        @(negedge clk);
        chk("R7 ch4 from ch2", gate_o & 6'b010101, 6'b010100);
    endtask

    task automatic t_pattern();
        do_reset();
        wr(4'd8, 5'd9);
        wr(4'd9, 5'd10);
        wr(4'd10, 5'd8);
        wr(4'd11, 5'd12);
        wr(4'd12, 5'd11);
        wr(4'd13, 5'd13);
        @(negedge clk);
        chk("R8 idle", gate_o, 6'b011010);
        pat_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 present", gate_o, 6'b000111);
        pat_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 gone", gate_o, 6'b110001);
        wr(4'hF, 5'd0);
        @(negedge clk);
        chk("R9 clear", gate_o, 6'b011010);
    endtask

    task automatic t_unused_gate();
        do_reset();
        wr(4'd8, 5'd4);
        wr(4'd9, 5'd20);
        wr(4'd11, 5'd5);
        @(negedge clk);
        chk("R10 reserved gates off", gate_o, 6'b110100);
    endtask

    task automatic t_addr();
        do_reset();
        wr(4'd2, 5'd3);
        chk("R13 only ch2 clk", clk_oe_o, 6'b000100);
        chk("R13 gate untouched", gate_oe_o, 6'h3f);
        wr(4'd7, 5'd5);
        wr(4'd14, 5'd2);
        chk("R13 unused address clk", clk_oe_o, 6'b000100);
        chk("R13 unused address gate", gate_oe_o, 6'h3f);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_pin_clocks();
        t_ring_clock();
        t_rates();
        t_fixed_clock();
        t_gates();
        t_ring_gate();
        t_pattern();
        t_unused_gate();
        t_addr();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule